// File: doc/BRIEF.md
# Width-Converting FIFO with Half-Word Order Select

This block is a single-clock first-in first-out buffer. Its write port always takes 18-bit words. Its read port runs in one of two widths. In wide mode each read returns a whole stored word. In narrow mode each stored word is returned as two 9-bit reads, and the word is released only once both halves have been read.

Two configuration pins set the behaviour, and both are captured only while master reset is held:
- the width pin chooses wide or narrow reading;
- the order pin chooses which half comes out first in narrow mode.

After reset releases, both settings stay fixed until the next master reset, whatever the pins do.

The read data is presented show-ahead: the head word, or the head half, is visible on the output before it is popped. The output is qualified by a valid flag, which stands in for a high-impedance driver. The flag is high only when two conditions hold:
- the chip-select, registered on the clock, is active;
- the combinational output-enable is active.

Top module: `wconv_fifo`

## Requirements
- R1: While master reset `mrst` is high and on the cycle after it falls, `empty` is 1 and `full` is 0.
- R2: In wide mode (`cfgNarrow` low at reset), `rdData` shows the oldest stored word in full, and each accepted read removes exactly one word, in write order.
- R3: In narrow big-endian mode (`cfgNarrow`=1 and `cfgBigEnd`=1 at reset), the first read of a word shows its bits 17:9 and the second shows its bits 8:0. Each half appears on `rdData[8:0]` with `rdData[17:9]` at zero.
- R4: In narrow little-endian mode (`cfgNarrow`=1, `cfgBigEnd`=0 at reset), the first read of a word shows bits 8:0 and the second shows bits 17:9, placed as in R3.
- R5: Changing `cfgBigEnd` or `cfgNarrow` while `mrst` is low has no effect on the read width or the half order.
- R6: `full` rises after DEPTH words are stored without reads. A write while `full` is ignored: the stored contents and their order are unchanged.
- R7: A read while `empty` is ignored. It changes neither the stored data nor which half comes out next.
- R8: `rdValid` is high only when `outEn` is high and `rdSel` was high at the previous clock edge. When `rdValid` is low, `rdData` is zero. `outEn` acts in the same cycle, while `rdSel` acts one clock later.
- R9: A read and a write accepted in the same cycle leave the occupancy unchanged. When `full`, a simultaneous write is dropped while the read still pops.
- R10: In narrow mode `empty` stays low after the first half of the last word is read, and rises only after its second half is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, active high, synchronous; also captures the configuration pins |
| cfgBigEnd | input | 1 | Half order: 1 gives upper half first, sampled during reset |
| cfgNarrow | input | 1 | Read width: 1 gives 9-bit reads, 0 gives 18-bit reads, sampled during reset |
| wrEn | input | 1 | Write request |
| wrData | input | 18 | Word to store |
| rdEn | input | 1 | Read request: pops a word or a half |
| rdSel | input | 1 | Read chip-select, registered on the clock |
| outEn | input | 1 | Combinational output enable |
| rdData | output | 18 | Head word or head half; zero when not valid |
| rdValid | output | 1 | Output driven (registered chip-select AND output enable) |
| empty | output | 1 | No stored data left to read |
| full | output | 1 | All word slots occupied |

## Verification
A write and a read can land in the same clock edge. The bench provokes this twice:
- with one word stored, where both operations must be taken and the occupancy held;
- with the buffer full, where the write must be lost and the read still performed.

Each outcome is judged at the ports. The bench checks the flags, then drains the buffer and compares the drained sequence against the words it expects: the newer word should appear in the first case, and the dropped word should never appear in the second.

// File: rtl/wconv_fifo_pkg.sv
package wconv_fifo_pkg;

  // Strobes and latched modes passed from control to datapath
  typedef struct packed {
    logic wrPush;   // store wrData at wrAddr this cycle
    logic halfSel;  // 0: first half of head word is next, 1: second half
    logic bigEnd;   // latched half order
    logic narrow;   // latched read width
  } wconv_ctl_t;

endpackage

// File: rtl/wconv_fifo_ctrl.sv
module wconv_fifo_ctrl
  import wconv_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          cfgBigEnd,
  input  logic          cfgNarrow,
  input  logic          wrEn,
  input  logic          rdEn,
  output wconv_ctl_t    ctl,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          empty,
  output logic          full
);

  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   occ;
  logic          halfQ, bigQ, narrowQ;
  logic          wrOk, rdOk, popWord;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (occ == '0);
  assign full    = (occ == (AW+1)'(DEPTH));
  assign wrOk    = wrEn && !full;
  assign rdOk    = rdEn && !empty;
  // a word leaves only on a wide read or on the second half of a narrow read
  assign popWord = rdOk && (!narrowQ || halfQ);

  always_ff @(posedge clk) begin
    if (mrst) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      occ     <= '0;
      halfQ   <= 1'b0;
      bigQ    <= cfgBigEnd;
      narrowQ <= cfgNarrow;
    end else begin
      if (wrOk)    wrPtr <= nextPtr(wrPtr);
      if (popWord) rdPtr <= nextPtr(rdPtr);
      if (rdOk && narrowQ) halfQ <= !halfQ;
      case ({wrOk, popWord})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign wrAddr      = wrPtr;
  assign rdAddr      = rdPtr;
  assign ctl.wrPush  = wrOk;
  assign ctl.halfSel = halfQ;
  assign ctl.bigEnd  = bigQ;
  assign ctl.narrow  = narrowQ;

endmodule

// File: rtl/wconv_fifo_dp.sv
module wconv_fifo_dp
  import wconv_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 18,
  localparam int AW     = $clog2(DEPTH),
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              mrst,
  input  wconv_ctl_t        ctl,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdSel,
  input  logic              outEn,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] head, shaped;
  logic [HALF_W-1:0] upperHalf, lowerHalf;
  logic              csQ, takeUpper;

  always_ff @(posedge clk) begin
    if (ctl.wrPush) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (mrst) csQ <= 1'b0;
    else      csQ <= rdSel;
  end

  assign head      = mem[rdAddr];
  assign upperHalf = head[WORD_W-1:HALF_W];
  assign lowerHalf = head[HALF_W-1:0];
  // big-endian starts on the upper half; halfSel flips to the other half
  assign takeUpper = ctl.bigEnd ^ ctl.halfSel;

  always_comb begin
    if (ctl.narrow)
      shaped = {{(WORD_W-HALF_W){1'b0}}, (takeUpper ? upperHalf : lowerHalf)};
    else
      shaped = head;
  end

  assign rdValid = csQ && outEn;
  assign rdData  = rdValid ? shaped : '0;

endmodule

// File: rtl/wconv_fifo.sv
module wconv_fifo
  import wconv_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 18,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              cfgBigEnd,
  input  logic              cfgNarrow,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              rdSel,
  input  logic              outEn,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              empty,
  output logic              full
);

  wconv_ctl_t    ctl;
  logic [AW-1:0] wrAddr, rdAddr;

  wconv_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .mrst(mrst), .cfgBigEnd(cfgBigEnd), .cfgNarrow(cfgNarrow),
    .wrEn(wrEn), .rdEn(rdEn), .ctl(ctl), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .empty(empty), .full(full)
  );

  wconv_fifo_dp #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .mrst(mrst), .ctl(ctl), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdSel(rdSel), .outEn(outEn),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/wconv_fifo_chk.sv
module wconv_fifo_chk (
  input logic clk,
  input logic mrst,
  input logic wrEn,
  input logic rdEn,
  input logic rdSel,
  input logic outEn,
  input logic rdValid,
  input logic empty,
  input logic full
);

  assert_reset_flags_R1: assert property (@(posedge clk) disable iff (mrst)
    $past(mrst) |-> (empty && !full));

  assert_not_both_flags_R6: assert property (@(posedge clk) disable iff (mrst)
    !(empty && full));

  assert_full_holds_R6: assert property (@(posedge clk) disable iff (mrst)
    (full && wrEn && !rdEn) |=> full);

  assert_empty_holds_R7: assert property (@(posedge clk) disable iff (mrst)
    (empty && rdEn && !wrEn) |=> empty);

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (mrst)
    !outEn |-> !rdValid);

  assert_cs_gate_R8: assert property (@(posedge clk) disable iff (mrst)
    rdValid |-> $past(rdSel));

  assert_simul_keeps_R9: assert property (@(posedge clk) disable iff (mrst)
    (!empty && !full && wrEn && rdEn) |=> !empty);

endmodule

bind wconv_fifo wconv_fifo_chk u_chk (
  .clk(clk), .mrst(mrst), .wrEn(wrEn), .rdEn(rdEn), .rdSel(rdSel),
  .outEn(outEn), .rdValid(rdValid), .empty(empty), .full(full)
);

// File: tb/wconv_fifo_bench.sv
module wconv_fifo_bench;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        mrst = 1'b1;
  logic        cfgBigEnd = 1'b0, cfgNarrow = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0, rdSel = 1'b1, outEn = 1'b1;
  logic [17:0] wrData = '0;
  logic [17:0] rdData;
  logic        rdValid, empty, full;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wconv_fifo #(.DEPTH(DEPTH)) u_wconv_fifo (
    .clk(clk), .mrst(mrst), .cfgBigEnd(cfgBigEnd), .cfgNarrow(cfgNarrow),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdSel(rdSel), .outEn(outEn),
    .rdData(rdData), .rdValid(rdValid), .empty(empty), .full(full)
  );

  task automatic chk(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reset with given config, then flip the config pins (must not matter, R5)
  task automatic doReset(input bit big, input bit narrow);
    @(negedge clk);
    mrst = 1'b1; cfgBigEnd = big; cfgNarrow = narrow;
    wrEn = 0; rdEn = 0; rdSel = 1; outEn = 1;
    @(negedge clk);
    chk(empty === 1 && full === 0, "R1 in reset", {16'b0, empty, full}, 18'h2);
    @(negedge clk);
    mrst = 1'b0;
    cfgBigEnd = !big; cfgNarrow = !narrow;
    @(negedge clk);
    chk(empty === 1 && full === 0, "R1 after reset", {16'b0, empty, full}, 18'h2);
  endtask

  task automatic push(input logic [17:0] w);
    wrEn = 1; wrData = w;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic popCheck(input logic [17:0] exp, input string req);
    chk(rdValid === 1 && rdData === exp, req, rdData, exp);
    rdEn = 1;
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic t_wide();
    doReset(0, 0);
    push(18'h2ABCD); push(18'h01234); push(18'h3F00F);
    popCheck(18'h2ABCD, "R2 word0");
    popCheck(18'h01234, "R2 word1");
    popCheck(18'h3F00F, "R2 word2");
    chk(empty === 1, "R2 empty after drain", {17'b0, empty}, 18'h1);
  endtask

  task automatic t_narrowBig();
    logic [17:0] w = 18'h35A3C;
    doReset(1, 1);
    push(w);
    popCheck({9'b0, w[17:9]}, "R3 first upper");
    chk(empty === 0, "R10 not empty mid word", {17'b0, empty}, 18'h0);
    popCheck({9'b0, w[8:0]}, "R3 second lower");
    chk(empty === 1, "R10 empty after second half", {17'b0, empty}, 18'h1);
  endtask

  task automatic t_narrowLittle();
    logic [17:0] a = 18'h1C3F5, b = 18'h2E601;
    doReset(0, 1);
    push(a); push(b);
    popCheck({9'b0, a[8:0]},  "R4 a lower first");
    popCheck({9'b0, a[17:9]}, "R4 a upper second");
    popCheck({9'b0, b[8:0]},  "R4 b lower first");
    popCheck({9'b0, b[17:9]}, "R4 b upper second");
    chk(empty === 1, "R10 empty after drain", {17'b0, empty}, 18'h1);
  endtask

  task automatic t_cfgLatch();
    logic [17:0] w = 18'h3D2B7;
    doReset(1, 1);
    cfgBigEnd = 0; cfgNarrow = 0;
    @(negedge clk);
    push(w);
    popCheck({9'b0, w[17:9]}, "R5 mode kept narrow big");
    popCheck({9'b0, w[8:0]},  "R5 mode kept second half");
  endtask

  task automatic t_full();
    doReset(0, 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk(full === 0, "R6 not full early", {17'b0, full}, 18'h0);
      push(18'(i + 1));
    end
    chk(full === 1, "R6 full", {17'b0, full}, 18'h1);
    push(18'h3FFFF);
    chk(full === 1, "R6 still full", {17'b0, full}, 18'h1);
    for (int i = 0; i < DEPTH; i++) popCheck(18'(i + 1), "R6 contents kept");
    chk(empty === 1, "R6 dropped write absent", {17'b0, empty}, 18'h1);
  endtask

  task automatic t_emptyRead();
    logic [17:0] w = 18'h2468B;
    doReset(1, 1);
    rdEn = 1;
    @(negedge clk);
    rdEn = 0;
    chk(empty === 1, "R7 empty after read", {17'b0, empty}, 18'h1);
    push(w);
    popCheck({9'b0, w[17:9]}, "R7 half order untouched");
    popCheck({9'b0, w[8:0]},  "R7 second half");
  endtask

  task automatic t_gate();
    logic [17:0] w = 18'h15555;
    doReset(0, 0);
    push(w);
    outEn = 0; #1;
    chk(rdValid === 0 && rdData === 0, "R8 oe off same cycle", rdData, 18'h0);
    outEn = 1; #1;
    chk(rdValid === 1 && rdData === w, "R8 oe on", rdData, w);
    @(negedge clk);
    rdSel = 0; #1;
    chk(rdValid === 1, "R8 cs registered", {17'b0, rdValid}, 18'h1);
    @(negedge clk);
    chk(rdValid === 0 && rdData === 0, "R8 cs off next cycle", rdData, 18'h0);
    rdSel = 1;
    @(negedge clk);
    chk(rdValid === 1 && rdData === w, "R8 cs back on", rdData, w);
  endtask

  task automatic t_simul();
    doReset(0, 0);
    push(18'h00AAA);
    wrEn = 1; wrData = 18'h00BBB; rdEn = 1;
    @(negedge clk);
    wrEn = 0; rdEn = 0;
    chk(empty === 0, "R9 occupancy held", {17'b0, empty}, 18'h0);
    popCheck(18'h00BBB, "R9 newer word remains");
    chk(empty === 1, "R9 single word", {17'b0, empty}, 18'h1);
    for (int i = 0; i < DEPTH; i++) push(18'(i + 1));
    wrEn = 1; wrData = 18'h3CCCC; rdEn = 1;
    @(negedge clk);
    wrEn = 0; rdEn = 0;
    chk(full === 0, "R9 full read pops", {17'b0, full}, 18'h0);
    for (int i = 1; i < DEPTH; i++) popCheck(18'(i + 1), "R9 write dropped when full");
    chk(empty === 1, "R9 drained", {17'b0, empty}, 18'h1);
  endtask

  initial begin
    t_wide();
    t_narrowBig();
    t_narrowLittle();
    t_cfgLatch();
    t_full();
    t_emptyRead();
    t_gate();
    t_simul();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule